// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This unit performs the bit-level and pixel-level operations that a graphics datapath needs on 32-bit words. A 4-bit opcode selects one function per request:
- a left rotate;
- a low-order mask of a given width;
- replication of a small field across the whole word;
- a search for the position of a set bit or of a transition between neighbouring bits;
- an addition that runs either as one 32-bit lane or as four carry-isolated 8-bit lanes.

Each request presents two operands, a 5-bit amount and the opcode, with a request strobe. The result appears in an output register one clock later, together with a valid flag. The search functions also raise a not-found flag.

Typical use is inside an execution stage. The replicator turns monochrome bitmaps into colour fills. The mask generator and the rotator together isolate and place fields. The split adder processes four 8-bit pixels per cycle.

Top module: `bfu_top`

## Requirements
- R1: Opcode 0 rotates `opa` left by `amt` positions, so bit i moves to bit (i+amt) mod 32. An `amt` of 0 returns `opa` unchanged.
- R2: Opcode 1 returns 2^amt − 1, a word whose `amt` low bits are one and whose other bits are zero. An `amt` of 0 gives zero.
- R3: Opcodes 2, 3 and 4 replicate the low 1, 2 or 4 bits of `opa` 32, 16 or 8 times. Field bit 0 lands on result bit 0, so result bit i equals `opa`[i mod width].
- R4: Opcode 5 returns the index of the highest set bit of `opa`. Opcode 6 returns the index of the lowest set bit.
- R5: A change exists at index i (1..31) when `opa`[i] differs from `opa`[i−1], and it is reported as index i. Opcode 7 returns the highest such index and opcode 8 the lowest.
- R6: When opcodes 5–8 find no match, the result is 32 and `not_found` is 1. No match means an all-zero word for opcodes 5–6, or an all-equal word for opcodes 7–8. In every other case `not_found` is 0.
- R7: Opcode 9 returns (`opa` + `opb`) mod 2^32, with the carry running across all 32 bits.
- R8: Opcode 10 adds the four byte lanes (bits 8k+7..8k) independently, each mod 256. No carry crosses a lane boundary.
- R9: `res_valid` equals `req_valid` of the previous cycle. `result` and `not_found` load only when a request is accepted, and hold their value otherwise.
- R10: While `rst` is high at a clock edge, `res_valid`, `result` and `not_found` become 0.
- R11: Opcodes 11 to 15 produce a result of 0 with `not_found` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| opcode | input | 4 | Function select (see R1–R11) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, used by the adders |
| amt | input | 5 | Rotate amount or mask width |
| res_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Registered result |
| not_found | output | 1 | Search found no match |

## Verification
All state is a single output register, so a wrong function path or a wrong register update shows on `result` or `not_found` in the very next cycle after the request. A fault in the hold logic shows as soon as an idle cycle follows a request. A reference model predicts every cycle's outputs, covering idle cycles too, so a stale or spurious value is caught within one clock. Corner inputs target the edges where errors hide: rotate and mask amounts of 0 and 31, searches over all-zero and all-one words, changes at bits 1 and 31, and carries at every byte boundary.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;

    typedef enum logic [3:0] {
        OP_ROTL   = 4'd0,
        OP_MASK   = 4'd1,
        OP_EXP1   = 4'd2,
        OP_EXP2   = 4'd3,
        OP_EXP4   = 4'd4,
        OP_LONE   = 4'd5,
        OP_RONE   = 4'd6,
        OP_LCHG   = 4'd7,
        OP_RCHG   = 4'd8,
        OP_ADD    = 4'd9,
        OP_ADD4X8 = 4'd10
    } bfu_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              none;
    } bfu_out_t;

    function automatic logic is_search(input bfu_op_e op);
        return (op == OP_LONE) || (op == OP_RONE) || (op == OP_LCHG) || (op == OP_RCHG);
    endfunction

    function automatic logic is_change(input bfu_op_e op);
        return (op == OP_LCHG) || (op == OP_RCHG);
    endfunction

endpackage

// File: rtl/bfu_rotmask.sv
module bfu_rotmask #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  rot,
    output logic [W-1:0]  mask
);
    logic [2*W-1:0] dbl;

    assign dbl = {a, a} << amt;
    assign rot = dbl[2*W-1:W];

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (amt > SW'(g));
    end
endmodule

// File: rtl/bfu_expand.sv
module bfu_expand #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [1:0]   fsel,
    output logic [W-1:0] y
);
    for (genvar g = 0; g < W; g++) begin : g_rep
        assign y[g] = (fsel == 2'd0) ? a[0]
                    : (fsel == 2'd1) ? a[g % 2]
                    :                  a[g % 4];
    end
endmodule

// File: rtl/bfu_detect.sv
module bfu_detect #(
    parameter int W  = 32,
    parameter int PW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    input  logic          from_left,
    output logic [PW-1:0] pos,
    output logic          found
);
    always_comb begin
        pos   = PW'(W);
        found = 1'b0;
        if (from_left) begin
            for (int i = 0; i < W; i++) begin
                if (vec[i]) begin
                    pos   = PW'(i);
                    found = 1'b1;
                end
            end
        end else begin
            for (int i = W - 1; i >= 0; i--) begin
                if (vec[i]) begin
                    pos   = PW'(i);
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bfu_addsplit.sv
module bfu_addsplit #(
    parameter int W  = 32,
    parameter int LW = 8,
    parameter int NL = W / LW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         split,
    output logic [W-1:0] sum
);
    logic [NL-1:0] cin;

    assign cin[0] = 1'b0;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        if (k < NL - 1) begin : g_mid
            logic [LW:0] s;
            assign s = {1'b0, a[k*LW +: LW]} + {1'b0, b[k*LW +: LW]} + {{LW{1'b0}}, cin[k]};
            assign sum[k*LW +: LW] = s[LW-1:0];
            assign cin[k+1] = s[LW] & ~split;
        end else begin : g_top
            assign sum[k*LW +: LW] = a[k*LW +: LW] + b[k*LW +: LW] + {{(LW-1){1'b0}}, cin[k]};
        end
    end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
    import bfu_pkg::*;
#(
    parameter  int W  = WORD_W,
    localparam int SW = $clog2(W),
    localparam int PW = SW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [3:0]    opcode,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [SW-1:0] amt,
    output logic          res_valid,
    output logic [W-1:0]  result,
    output logic          not_found
);
    bfu_op_e       op;
    logic [W-1:0]  rot_y, mask_y, exp_y, add_y, det_vec, chg_vec;
    logic [1:0]    fsel;
    logic [PW-1:0] det_pos;
    logic          det_found;
    bfu_out_t      nxt, out_q;

    assign op      = bfu_op_e'(opcode);
    assign chg_vec = {opa[W-1:1] ^ opa[W-2:0], 1'b0};
    assign det_vec = is_change(op) ? chg_vec : opa;
    assign fsel    = (op == OP_EXP1) ? 2'd0 : (op == OP_EXP2) ? 2'd1 : 2'd2;

    bfu_rotmask #(.W(W), .SW(SW)) u_rotmask (
        .a(opa), .amt(amt), .rot(rot_y), .mask(mask_y)
    );

    bfu_expand #(.W(W)) u_expand (
        .a(opa), .fsel(fsel), .y(exp_y)
    );

    bfu_detect #(.W(W), .PW(PW)) u_detect (
        .vec(det_vec), .from_left((op == OP_LONE) || (op == OP_LCHG)),
        .pos(det_pos), .found(det_found)
    );

    bfu_addsplit #(.W(W), .LW(LANE_W)) u_add (
        .a(opa), .b(opb), .split(op == OP_ADD4X8), .sum(add_y)
    );

    always_comb begin
        nxt = '0;
        case (op)
            OP_ROTL:                   nxt.value = rot_y;
            OP_MASK:                   nxt.value = mask_y;
            OP_EXP1, OP_EXP2, OP_EXP4: nxt.value = exp_y;
            OP_LONE, OP_RONE,
            OP_LCHG, OP_RCHG: begin
                nxt.value = {{(W-PW){1'b0}}, det_pos};
                nxt.none  = ~det_found;
            end
            OP_ADD, OP_ADD4X8:         nxt.value = add_y;
            default:                   nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            out_q     <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) out_q <= nxt;
        end
    end

    assign result    = out_q.value;
    assign not_found = out_q.none;

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(req_valid)));

    // R6
    none_value_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && not_found) |-> (result == W'(W)));

    // R2
    mask_form_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(opcode) == OP_MASK) |->
        (($countones(result) == int'($past(amt))) && ((result & (result + 1'b1)) == '0)));

    // R1
    rot_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(opcode) == OP_ROTL) |->
        ($countones(result) == $countones($past(opa))));

    // R8
    lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(opcode) == OP_ADD4X8) |->
        (result[LANE_W-1:0] == LANE_W'($past(opa[LANE_W-1:0]) + $past(opb[LANE_W-1:0]))));

    // R4
    lone_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(opcode) == OP_LONE && !not_found) |->
        ((($past(opa) >> result[SW-1:0]) & W'(1)) != '0));
endmodule

// File: tb/tb_bfu_top.sv
`timescale 1ns/1ps
module tb_bfu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] opa = '0, opb = '0;
    logic [4:0]  amt = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        not_found;

    int total = 0, fails = 0;
    bit done = 0;
    bit [31:0] exp_res = 0;
    bit        exp_nf = 0, exp_v = 0;
    int        last_op = 0;

    always #2.5 clk = ~clk;

    bfu_top dut (.*);

    function automatic string tag_of(int op);
        case (op)
            0: return "R1"; 1: return "R2"; 2, 3, 4: return "R3";
            5, 6: return "R4"; 7, 8: return "R5"; 9: return "R7";
            10: return "R8"; default: return "R11";
        endcase
    endfunction

    function automatic void model(input int op, input bit [31:0] a, input bit [31:0] b,
                                  input int n, output bit [31:0] r, output bit nf);
        int w;
        r = 0; nf = 0;
        case (op)
            0: for (int i = 0; i < 32; i++) r[(i + n) % 32] = a[i];
            1: for (int i = 0; i < n; i++) r[i] = 1'b1;
            2, 3, 4: begin
                w = (op == 2) ? 1 : (op == 3) ? 2 : 4;
                for (int i = 0; i < 32; i++) r[i] = a[i % w];
            end
            5, 6, 7, 8: begin
                r = 32; nf = 1;
                if (op == 5) begin
                    for (int i = 31; i >= 0; i--) if (nf && a[i]) begin r = i; nf = 0; end
                end else if (op == 6) begin
                    for (int i = 0; i < 32; i++) if (nf && a[i]) begin r = i; nf = 0; end
                end else if (op == 7) begin
                    for (int i = 31; i >= 1; i--) if (nf && a[i] != a[i-1]) begin r = i; nf = 0; end
                end else begin
                    for (int i = 1; i < 32; i++) if (nf && a[i] != a[i-1]) begin r = i; nf = 0; end
                end
            end
            9: r = a + b;
            10: for (int k = 0; k < 4; k++) r[8*k +: 8] = (int'(a[8*k +: 8]) + int'(b[8*k +: 8])) % 256;
            default: r = 0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input bit [31:0] act, input bit [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic compare();
        check("R9", "res_valid", {31'b0, res_valid}, {31'b0, exp_v});
        check(tag_of(last_op), "result", result, exp_res);
        check("R6", "not_found", {31'b0, not_found}, {31'b0, exp_nf});
    endtask

    task automatic step(input bit v, input int op, input bit [31:0] a, input bit [31:0] b, input int n);
        bit [31:0] r; bit nf;
        @(negedge clk);
        compare();
        req_valid = v; opcode = 4'(op); opa = a; opb = b; amt = 5'(n);
        exp_v = v;
        if (v) begin
            model(op, a, b, n, r, nf);
            exp_res = r; exp_nf = nf; last_op = op;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        req_valid = 1'b1; opcode = 4'd9; opa = 32'h1234; opb = 32'h1;
        repeat (3) @(negedge clk);
        // R10 reset state while reset held with a pending request
        check("R10", "reset res_valid", {31'b0, res_valid}, 32'd0);
        check("R10", "reset result", result, 32'd0);
        check("R10", "reset not_found", {31'b0, not_found}, 32'd0);
        rst = 1'b0; req_valid = 1'b0;
        // R1 rotate corners
        step(1, 0, 32'h8000_0001, 0, 0);
        step(1, 0, 32'h8000_0001, 0, 1);
        step(1, 0, 32'h8000_0001, 0, 31);
        step(1, 0, 32'hDEAD_BEEF, 0, 13);
        // R2 masks
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 1);
        step(1, 1, 0, 0, 16);
        step(1, 1, 32'hFFFF_FFFF, 0, 31);
        // R3 replication
        step(1, 2, 32'h0000_0001, 0, 0);
        step(1, 2, 32'hFFFF_FFFE, 0, 0);
        step(1, 3, 32'h0000_0002, 0, 0);
        step(1, 3, 32'hFFFF_FFF1, 0, 0);
        step(1, 4, 32'h0000_0005, 0, 0);
        step(1, 4, 32'h1234_567C, 0, 0);
        // R4 / R6 one search
        step(1, 5, 0, 0, 0);
        step(1, 5, 32'h0000_0001, 0, 0);
        step(1, 5, 32'h8000_0000, 0, 0);
        step(1, 6, 32'h00F0_0F00, 0, 0);
        step(1, 6, 0, 0, 0);
        step(1, 6, 32'h8000_0000, 0, 0);
        // R5 / R6 change search
        step(1, 7, 0, 0, 0);
        step(1, 7, 32'hFFFF_FFFF, 0, 0);
        step(1, 7, 32'h0000_0001, 0, 0);
        step(1, 7, 32'h8000_0000, 0, 0);
        step(1, 8, 32'h8000_0000, 0, 0);
        step(1, 8, 32'h0000_0001, 0, 0);
        step(1, 8, 32'hFFFF_FFFF, 0, 0);
        step(1, 8, 32'h0FF0_0000, 0, 0);
        // R7 / R8 carry behaviour
        step(1, 9, 32'hFFFF_FFFF, 32'h1, 0);
        step(1, 9, 32'h00FF_00FF, 32'h0001_0001, 0);
        step(1, 10, 32'hFFFF_FFFF, 32'h0101_0101, 0);
        step(1, 10, 32'h00FF_00FF, 32'h0001_0001, 0);
        step(1, 10, 32'h7F80_FF01, 32'h0180_01FF, 0);
        // R9 hold across idle cycles with changing inputs
        step(0, 9, 32'h1111_1111, 32'h2222_2222, 7);
        step(0, 1, 32'h0, 32'h0, 20);
        step(1, 5, 0, 0, 0);
        step(0, 9, 32'h5, 32'h5, 3);
        // R11 undefined opcodes
        for (int op = 11; op < 16; op++) step(1, op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 31);
        // randomised mix
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, $urandom % 16, $urandom, $urandom, $urandom % 32);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule